// File: doc/BRIEF.md
# Minimum-Deviation Load-Step Override Controller

This block sits between a linear compensator and the power stage driver of a buck converter. It stays transparent in normal operation and takes over only when a large load step happens. Two window comparators report that the output voltage has left its band, one for a drop below the lower curve and one for a rise above the upper curve. The block then forces the switch fully on or fully off and waits for a peak or valley flag from an external capacitor-voltage estimator. At that first extreme point it extends the forced level by a computed interval. It then drives the opposite level until the second extreme point and holds that level for a second computed interval. After that it hands the switch back to the compensator.

The two intervals are half of the switching period split in proportion to the steady-state duty. The short on interval is D·Tsw/2 and the off interval is (1−D)·Tsw/2, both counted in clock ticks. While the override runs, an active flag tells the compensator to freeze its state. A one-cycle resume pulse marks the handover back. A watchdog ends the override if an expected extreme point never arrives. A blanking period of one switching period keeps the block from retriggering right after it finishes.

Top module: `mindev_transient_ctrl`

## Requirements
- R1: After reset, and whenever no override is active and no resume pulse is present, `ovr_active` and `resume_pid` are 0 and `pwm_out` equals `pid_pwm` in the same cycle.
- R2: When idle and not blanked, a 1 on `v_under` sampled at a clock edge makes `ovr_active` 1 and `pwm_out` 1 from the next cycle on. A 1 on `v_over` alone does the same with `pwm_out` 0. If both are 1, `v_under` wins.
- R3: The intervals are computed from `duty_ss` (D = duty_ss/8192) and `sw_period` (P ticks). They are ton = floor(duty_ss·P/16384) and toff = floor((8192−duty_ss)·P/16384). The inputs are latched at the detection edge, so changes to `duty_ss` or `sw_period` during an override have no effect on it.
- R4: For a low-side detection (`v_under`), the sequence runs as follows. `pwm_out` is held at 1 up to and including the cycle in which `extremum` is sampled, then stays 1 for max(1, ton) more cycles. It is then held at 0 up to and including the cycle of the next sampled `extremum`, then stays 0 for max(1, toff) more cycles. `ovr_active` is 1 for that whole span.
- R5: For a high-side detection (`v_over`), the sequence of R4 is mirrored. The levels are inverted, the first timed interval lasts max(1, toff) and the second lasts max(1, ton).
- R6: `extremum` is ignored during both timed intervals and has no effect on their length.
- R7: If `extremum` is not sampled within WD_TICKS cycles of entering either wait phase (the initial forced phase or the second-level wait), the override ends and the resume cycle follows at once.
- R8: The cycle right after the override ends is a resume cycle. In it `resume_pid` is 1 for exactly one cycle, `ovr_active` is 0 and `pwm_out` follows `pid_pwm`.
- R9: After the resume cycle, detection flags are ignored for P idle cycles, where P is the latched period. With a flag held high from the resume cycle on, the override restarts in the (P+2)th cycle after resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, one timer tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| pid_pwm | input | 1 | Switch command from the linear compensator |
| duty_ss | input | DUTY_W (13) | Steady-state duty, fraction of 2^DUTY_W |
| sw_period | input | PER_W (12) | Switching period in clock ticks |
| v_under | input | 1 | Output crossed the lower transient curve |
| v_over | input | 1 | Output crossed the upper transient curve |
| extremum | input | 1 | Capacitor-voltage estimate at a peak or valley |
| pwm_out | output | 1 | Switch command to the driver |
| ovr_active | output | 1 | Override running; compensator must hold its state |
| resume_pid | output | 1 | One-cycle pulse handing control back |

## Verification
The bench sweeps the duty and period space, including duty 0 and full scale and a zero period, so that one or both timed intervals collapse to the one-cycle minimum. A design that skipped an empty interval or truncated the product differently would shift every later edge by a cycle. Every run moves the duty and period inputs after detection and holds the extreme flag high through the timed intervals. A design that reread its inputs or cut an interval short on a spurious extreme would show up as a wrong pulse length. Watchdog runs starve either wait phase, which catches a timeout that is off by one or missing in the second phase. Blanking runs hold a flag high across the resume cycle, which catches a restart one cycle early or late.

// File: rtl/mindev_transient_ctrl.sv
module mindev_transient_ctrl #(
  parameter int DUTY_W   = 13,
  parameter int PER_W    = 12,
  parameter int WD_TICKS = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pid_pwm,
  input  logic [DUTY_W-1:0] duty_ss,
  input  logic [PER_W-1:0]  sw_period,
  input  logic              v_under,
  input  logic              v_over,
  input  logic              extremum,
  output logic              pwm_out,
  output logic              ovr_active,
  output logic              resume_pid
);

  localparam int WD_W = $clog2(WD_TICKS);
  localparam int TW   = (PER_W > WD_W) ? PER_W : WD_W;
  localparam int PW   = DUTY_W + PER_W + 1;
  localparam logic [TW-1:0] WD_LOAD = TW'(WD_TICKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_RAMP, S_EXT, S_WAIT, S_HOLD, S_RESUME} st_t;

  st_t              st;
  logic             up;
  logic [PER_W-1:0] ton_r, toff_r, per_r, blank;
  logic [TW-1:0]    tmr;

  logic [DUTY_W:0]  compl_d;
  logic [PW-1:0]    p_on, p_off;
  logic [PER_W-1:0] seg1, seg2;

  // complement of duty and the two half-period products
  assign compl_d = {1'b1, {DUTY_W{1'b0}}} - {1'b0, duty_ss};
  assign p_on    = {{(PER_W+1){1'b0}}, duty_ss} * {{(DUTY_W+1){1'b0}}, sw_period};
  assign p_off   = {{PER_W{1'b0}}, compl_d} * {{(DUTY_W+1){1'b0}}, sw_period};

  assign seg1 = up ? ton_r  : toff_r;
  assign seg2 = up ? toff_r : ton_r;

  assign ovr_active = (st == S_RAMP) || (st == S_EXT) || (st == S_WAIT) || (st == S_HOLD);
  assign resume_pid = (st == S_RESUME);
  assign pwm_out    = !ovr_active ? pid_pwm
                    : ((st == S_RAMP) || (st == S_EXT)) ? up : !up;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      up     <= 1'b0;
      ton_r  <= '0;
      toff_r <= '0;
      per_r  <= '0;
      blank  <= '0;
      tmr    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          ton_r  <= p_on[PW-2:DUTY_W+1];
          toff_r <= p_off[PW-2:DUTY_W+1];
          per_r  <= sw_period;
          if (blank != '0) begin
            blank <= blank - 1'b1;
          end else if (v_under || v_over) begin
            up  <= v_under;
            st  <= S_RAMP;
            tmr <= WD_LOAD;
          end
        end
        S_RAMP: begin
          if (extremum) begin
            st  <= S_EXT;
            tmr <= TW'(seg1);
          end else if (tmr == '0) begin
            st <= S_RESUME;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_EXT: begin
          if (tmr <= TW'(1)) begin
            st  <= S_WAIT;
            tmr <= WD_LOAD;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_WAIT: begin
          if (extremum) begin
            st  <= S_HOLD;
            tmr <= TW'(seg2);
          end else if (tmr == '0) begin
            st <= S_RESUME;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        S_HOLD: begin
          if (tmr <= TW'(1)) st <= S_RESUME;
          else               tmr <= tmr - 1'b1;
        end
        default: begin
          st    <= S_IDLE;
          blank <= per_r;
        end
      endcase
    end
  end

endmodule

// File: rtl/mindev_transient_ctrl_chk.sv
module mindev_transient_ctrl_chk #(
  parameter int PER_W    = 12,
  parameter int WD_TICKS = 4096
) (
  input logic clk,
  input logic rst_n,
  input logic pid_pwm,
  input logic v_under,
  input logic v_over,
  input logic extremum,
  input logic pwm_out,
  input logic ovr_active,
  input logic resume_pid
);

  localparam int LIMIT = 2 * WD_TICKS + 2 * (1 << PER_W);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (ovr_active) run_len <= run_len + 1;
    else                 run_len <= '0;
  end

  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_active |-> (pwm_out == pid_pwm));

  a_r2_started_by_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_active) |-> $past(v_under || v_over));

  a_r7_override_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= LIMIT);

  a_r8_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pid |=> !resume_pid);

  a_r8_resume_after_override: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_active) |-> resume_pid);

  a_r8_resume_excl: assert property (@(posedge clk) disable iff (!rst_n)
    resume_pid |-> (!ovr_active && $past(ovr_active)));

endmodule

bind mindev_transient_ctrl mindev_transient_ctrl_chk #(.PER_W(PER_W), .WD_TICKS(WD_TICKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pid_pwm(pid_pwm), .v_under(v_under), .v_over(v_over),
  .extremum(extremum), .pwm_out(pwm_out), .ovr_active(ovr_active), .resume_pid(resume_pid)
);

// File: tb/mindev_transient_ctrl_test.sv
module mindev_transient_ctrl_test;

  localparam int DW = 13;
  localparam int PWD = 6;
  localparam int WD = 40;

  logic clk = 0;
  logic rst_n = 0;
  logic pid_pwm = 0;
  logic [DW-1:0] duty_ss = '0;
  logic [PWD-1:0] sw_period = '0;
  logic v_under = 0, v_over = 0, extremum = 0;
  logic pwm_out, ovr_active, resume_pid;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mindev_transient_ctrl #(.DUTY_W(DW), .PER_W(PWD), .WD_TICKS(WD)) uut (
    .clk(clk), .rst_n(rst_n), .pid_pwm(pid_pwm), .duty_ss(duty_ss), .sw_period(sw_period),
    .v_under(v_under), .v_over(v_over), .extremum(extremum),
    .pwm_out(pwm_out), .ovr_active(ovr_active), .resume_pid(resume_pid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // wd: 0 normal, 1 starve first wait, 2 starve second wait
  task automatic run_seq(input bit up, input bit both, input int duty, input int per,
                         input int r, input int w, input int wd, input bit blank_test);
    int ton, toff, e, h, p1, act_end, res, last;
    ton  = (duty * per) >> 14;
    toff = ((8192 - duty) * per) >> 14;
    e = up ? ton : toff;  if (e < 1) e = 1;
    h = up ? toff : ton;  if (h < 1) h = 1;
    if (wd == 1) begin p1 = WD - 1; act_end = p1; end
    else if (wd == 2) begin p1 = r + e; act_end = p1 + WD; end
    else begin p1 = r + e; act_end = p1 + 1 + w + h; end
    res  = act_end + 1;
    last = blank_test ? res + 2 + per : res + per + 2;

    @(negedge clk);
    duty_ss   = DW'(duty);
    sw_period = PWD'(per);
    v_under   = up;
    v_over    = !up || both;
    extremum  = 0;
    for (int k = 0; k <= last; k++) begin
      int exp_act, exp_res, exp_pwm;
      @(negedge clk);
      pid_pwm = (k % 2 == 1);
      if (k == 0) begin
        v_under = 0; v_over = 0;
        duty_ss = DW'(duty ^ 13'h0a5a);  // R3: ignored once latched
        sw_period = PWD'(per ^ 21);
      end
      if (k == 1) sw_period = PWD'(per); // restore so the blanking tail is unchanged
      if (blank_test && k >= res) v_under = 1;
      #1;
      exp_act = (k <= act_end) ? 1 : 0;
      exp_res = (k == res) ? 1 : 0;
      exp_pwm = (k <= p1) ? up : (k <= act_end) ? !up : (k % 2);
      if (blank_test && k == res + 2 + per) begin
        chk(ovr_active == 1, "R9 restart after blanking", ovr_active, 1);
        chk(pwm_out == 1, "R9 restart level", pwm_out, 1);
      end else begin
        chk(ovr_active == exp_act[0],
            (k > res) ? "R9 blanked idle" : (up ? "R4 active" : "R5 active"), ovr_active, exp_act);
        chk(resume_pid == exp_res[0], "R8 resume pulse", resume_pid, exp_res);
        chk(pwm_out == exp_pwm[0],
            (wd != 0) ? "R7 watchdog pwm" : (k >= res ? "R8 passthrough" :
            (up ? (both ? "R2 both flags" : "R4 pwm/R3 ton") : "R5 pwm/R3 toff")),
            pwm_out, exp_pwm);
      end
      extremum = 0;
      if (wd != 1 && k == r) extremum = 1;
      if (wd == 0 && k == p1 + 1 + w) extremum = 1;
      if (k > r && k < p1 && wd != 1) extremum = 1;           // R6 noise in first interval
      if (wd == 0 && k > p1 + 1 + w && k < act_end) extremum = 1; // R6 noise in second interval
    end
    if (blank_test) begin
      @(negedge clk);
      v_under = 0;
      repeat (WD + per + 6) @(negedge clk);
    end
  endtask

  initial begin
    int duties[6] = '{0, 1, 2048, 4096, 5000, 8191};
    int pers[4]   = '{0, 9, 37, 63};
    int idx = 0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pid_pwm = (k % 2 == 1);
      #1;
      chk(ovr_active == 0, "R1 reset active", ovr_active, 0);
      chk(resume_pid == 0, "R1 reset resume", resume_pid, 0);
      chk(pwm_out == pid_pwm, "R1 reset passthrough", pwm_out, pid_pwm);
    end
    rst_n = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      pid_pwm = (k % 2 == 0);
      #1;
      chk(pwm_out == pid_pwm && !ovr_active, "R1 idle passthrough", pwm_out, pid_pwm);
    end
    for (int pi = 0; pi < 4; pi++)
      for (int di = 0; di < 6; di++)
        for (int u = 0; u < 2; u++) begin
          run_seq(u[0], (u == 1) && (di % 2 == 1), duties[di], pers[pi], idx % 3, (idx % 4) * 2, 0, 0);
          idx++;
        end
    run_seq(1, 0, 3000, 20, 0, 0, 1, 0);
    run_seq(0, 0, 3000, 20, 1, 0, 1, 0);
    run_seq(1, 0, 6000, 30, 2, 0, 2, 0);
    run_seq(0, 0, 1000, 30, 0, 0, 2, 0);
    run_seq(1, 0, 4096, 12, 1, 3, 0, 1);
    run_seq(0, 0, 7000, 25, 0, 1, 0, 1);
    run_seq(1, 0, 2000, 0, 0, 0, 0, 1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule